// File: doc/BRIEF.md
# Multi-View General Register File

This block holds sixteen 64-bit general registers and lets each one be read or written through a narrower window: a low byte, the byte just above it, a 16-bit half-word, a 32-bit word, or the whole 64-bit register. It has one write port and two independent read ports. Each read port returns its selected window shifted down to bit 0, with the upper bits filled with zeros.

A mode input chooses between a legacy 32-bit operating mode and a wide 64-bit mode. Some register and window pairs are valid only in wide mode, and the second byte exists only on the first four registers. An invalid write raises an error flag on that cycle and leaves every register untouched. An invalid read raises that port's error flag and returns zero.

Narrow writes follow two different policies:
- A byte or half-word write merges into the register, so every other bit keeps its value.
- A 32-bit write clears the upper half of the register.

Top module: `gpr_view_file`

## Requirements
- R1: A synchronous active-high reset sets every register to zero.
- R2: A write with view code 0 changes bits 7..0 only, and bits 63..8 keep their values.
- R3: View code 1 addresses bits 15..8. A write with it changes those bits only. It is legal only for registers 0 to 3, and on any other register the write is flagged and dropped.
- R4: A write with view code 2 changes bits 15..0 only, and bits 63..16 keep their values.
- R5: A write with view code 3 sets bits 31..0 to the data and bits 63..32 to zero.
- R6: View code 4 addresses all 64 bits. It is legal only in wide mode (mode input 1).
- R7: A read returns its window right-aligned and zero-extended, combinationally from the index and view.
- R8: Registers 8 to 15 are accessible only in wide mode. In legacy mode (mode input 0) any access to them is flagged.
- R9: View code 0 on registers 4 to 7 is legal only in wide mode.
- R10: View codes 5, 6 and 7 are always illegal.
- R11: When a write is illegal, the write error flag is high in that cycle and no register changes. When a read is illegal, that port's error flag is high and its data is zero.
- R12: A read of the register being written in the same cycle returns the value it held before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 = 64-bit mode, 0 = legacy 32-bit mode |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write register index |
| wr_view | input | 3 | Write view code |
| wr_data | input | 64 | Write data, right-aligned |
| wr_err | output | 1 | Current write request is illegal |
| ra_idx | input | 4 | Read port A register index |
| ra_view | input | 3 | Read port A view code |
| ra_data | output | 64 | Read port A data, zero-extended |
| ra_err | output | 1 | Read port A request is illegal |
| rb_idx | input | 4 | Read port B register index |
| rb_view | input | 3 | Read port B view code |
| rb_data | output | 64 | Read port B data, zero-extended |
| rb_err | output | 1 | Read port B request is illegal |

## Verification
The assertions take two things for granted:
- The mode input is steady across the cycle in which a write is decided.
- The write error flag is meaningful only while a write is requested.

Given those, the assertions check the merge rules and the protected state from one edge to the next. The stimulus changes the mode, the indices, the views and the data only on falling edges. It keeps the write enable low while reads are checked on their own. All 64 bits are read back through the wide view, so that the effect of each write, merged or dropped, can be seen at the ports.

// File: rtl/gpr_view_file.sv
module gpr_view_file #(
  parameter int NREG    = 16,
  parameter int NLEGACY = 8,
  parameter int NHIGH   = 4,
  parameter int XLEN    = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wide_mode,
  input  logic                     wr_en,
  input  logic [$clog2(NREG)-1:0]  wr_idx,
  input  logic [2:0]               wr_view,
  input  logic [XLEN-1:0]          wr_data,
  output logic                     wr_err,
  input  logic [$clog2(NREG)-1:0]  ra_idx,
  input  logic [2:0]               ra_view,
  output logic [XLEN-1:0]          ra_data,
  output logic                     ra_err,
  input  logic [$clog2(NREG)-1:0]  rb_idx,
  input  logic [2:0]               rb_view,
  output logic [XLEN-1:0]          rb_data,
  output logic                     rb_err
);
  localparam int IW   = $clog2(NREG);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0]      rf [NREG];
  logic [NREG*XLEN-1:0] rf_flat;

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign rf_flat[g*XLEN +: XLEN] = rf[g];
  end

  function automatic logic legal(input logic [IW-1:0] idx, input logic [2:0] view,
                                 input logic wide);
    logic reach;
    reach = wide || (32'(idx) < NLEGACY);
    case (view)
      3'd0:    return reach && (wide || 32'(idx) < NHIGH);
      3'd1:    return reach && (32'(idx) < NHIGH);
      3'd2,
      3'd3:    return reach;
      3'd4:    return wide;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] slice(input logic [XLEN-1:0] r, input logic [2:0] view);
    case (view)
      3'd0:    return {{(XLEN-8){1'b0}}, r[7:0]};
      3'd1:    return {{(XLEN-8){1'b0}}, r[15:8]};
      3'd2:    return {{(XLEN-16){1'b0}}, r[15:0]};
      3'd3:    return {{HALF{1'b0}}, r[HALF-1:0]};
      3'd4:    return r;
      default: return '0;
    endcase
  endfunction

  logic ra_ok, rb_ok, wr_ok;
  assign wr_ok   = legal(wr_idx, wr_view, wide_mode);
  assign ra_ok   = legal(ra_idx, ra_view, wide_mode);
  assign rb_ok   = legal(rb_idx, rb_view, wide_mode);
  assign wr_err  = wr_en && !wr_ok;
  assign ra_err  = !ra_ok;
  assign rb_err  = !rb_ok;
  assign ra_data = ra_ok ? slice(rf[ra_idx], ra_view) : '0;
  assign rb_data = rb_ok ? slice(rf[rb_idx], rb_view) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wr_en && wr_ok) begin
      case (wr_view)
        3'd0:    rf[wr_idx][7:0]  <= wr_data[7:0];
        3'd1:    rf[wr_idx][15:8] <= wr_data[7:0];
        3'd2:    rf[wr_idx][15:0] <= wr_data[15:0];
        3'd3:    rf[wr_idx]       <= {{HALF{1'b0}}, wr_data[HALF-1:0]};
        default: rf[wr_idx]       <= wr_data;
      endcase
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> rf_flat == '0);

  assert_low_merge_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_err && wr_view == 3'd0) |=>
      rf[$past(wr_idx)][XLEN-1:8] == $past(rf[wr_idx][XLEN-1:8]));

  assert_high_merge_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_err && wr_view == 3'd1) |=>
      (rf[$past(wr_idx)][7:0] == $past(rf[wr_idx][7:0])) &&
      (rf[$past(wr_idx)][XLEN-1:16] == $past(rf[wr_idx][XLEN-1:16])));

  assert_half_merge_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_err && wr_view == 3'd2) |=>
      rf[$past(wr_idx)][XLEN-1:16] == $past(rf[wr_idx][XLEN-1:16]));

  assert_word_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_err && wr_view == 3'd3) |=> rf[$past(wr_idx)][XLEN-1:HALF] == '0);

  assert_drop_illegal_R11: assert property (@(posedge clk) disable iff (rst)
    (!wr_en || wr_err) |=> $stable(rf_flat));

  assert_read_zext_R7: assert property (@(posedge clk) disable iff (rst)
    (!ra_err && ra_view == 3'd1) |-> ra_data[XLEN-1:8] == '0);

  assert_wide_only_R6: assert property (@(posedge clk) disable iff (rst)
    (!wide_mode && wr_en && wr_view == 3'd4) |-> wr_err);
endmodule

// File: tb/gpr_view_file_test.sv
module gpr_view_file_test;
  logic clk = 0, rst = 1, wide_mode = 1, wr_en = 0;
  logic [3:0] wr_idx = 0, ra_idx = 0, rb_idx = 0;
  logic [2:0] wr_view = 0, ra_view = 0, rb_view = 0;
  logic [63:0] wr_data = 0, ra_data, rb_data;
  logic wr_err, ra_err, rb_err;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  gpr_view_file uut (.clk(clk), .rst(rst), .wide_mode(wide_mode), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_view(wr_view), .wr_data(wr_data), .wr_err(wr_err),
    .ra_idx(ra_idx), .ra_view(ra_view), .ra_data(ra_data), .ra_err(ra_err),
    .rb_idx(rb_idx), .rb_view(rb_view), .rb_data(rb_data), .rb_err(rb_err));

  typedef struct packed {
    logic        md; logic we; logic [3:0] wi; logic [2:0] wv; logic [63:0] wd;
    logic        xe; logic [3:0] ri; logic [2:0] rv; logic [63:0] xd;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1,1,0,4,64'h1122334455667788,0,0,4,64'h1122334455667788}, // R6
    '{1,1,0,0,64'hAA,0,0,4,64'h11223344556677AA},               // R2
    '{1,1,0,1,64'hBB,0,0,4,64'h112233445566BBAA},               // R3
    '{1,1,0,2,64'hCCDD,0,0,4,64'h112233445566CCDD},             // R4
    '{1,1,0,3,64'hFFFF0000DEADBEEF,0,0,4,64'h00000000DEADBEEF}, // R5
    '{1,0,0,0,0,0,0,1,64'hBE},                                  // R7
    '{1,0,0,0,0,0,0,2,64'hBEEF},                                // R7
    '{1,0,0,0,0,0,0,0,64'hEF},                                  // R7
    '{1,0,0,0,0,0,0,3,64'hDEADBEEF},                            // R7
    '{0,1,1,4,64'hFFFFFFFFFFFFFFFF,1,1,3,64'h0},                // R6 R11
    '{0,1,9,3,64'h1234,1,0,3,64'hDEADBEEF},                     // R8
    '{1,0,0,0,0,0,9,4,64'h0},                                   // R8
    '{0,1,5,0,64'h55,1,5,2,64'h0},                              // R9
    '{1,1,5,0,64'h55,0,5,4,64'h55},                             // R9
    '{1,1,4,1,64'h66,1,4,4,64'h0},                              // R3
    '{1,1,3,1,64'h77,0,3,4,64'h7700},                           // R3
    '{1,1,2,5,64'h99,1,2,4,64'h0},                              // R10
    '{1,1,2,7,64'h99,1,2,4,64'h0},                              // R10
    '{1,1,15,4,64'hA5A5A5A5A5A5A5A5,0,15,4,64'hA5A5A5A5A5A5A5A5},
    '{0,1,7,2,64'h1357,0,7,2,64'h1357}                          // R4
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    ra_view = 3'd4; rb_view = 3'd4;
    for (int i = 0; i < 16; i += 5) begin
      ra_idx = 4'(i); rb_idx = 4'(i + 1); #1;
      chk("R1 reset A", ra_data, 0);
      chk("R1 reset B", rb_data, 0);
      @(negedge clk);
    end

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wide_mode = VECS[i].md; wr_en = VECS[i].we; wr_idx = VECS[i].wi;
      wr_view = VECS[i].wv; wr_data = VECS[i].wd; #1;
      chk($sformatf("R11 wr_err vec %0d", i), 64'(wr_err), 64'(VECS[i].xe & VECS[i].we));
      @(negedge clk);
      wr_en = 0; ra_idx = VECS[i].ri; ra_view = VECS[i].rv; #1;
      chk($sformatf("R7 read vec %0d", i), ra_data, VECS[i].xd);
    end

    // R12: same-cycle read sees old value, new value after the edge
    @(negedge clk);
    wide_mode = 1; ra_idx = 15; ra_view = 4; rb_idx = 15; rb_view = 3;
    wr_en = 1; wr_idx = 15; wr_view = 4; wr_data = 64'h0123456789ABCDEF; #1;
    chk("R12 old A", ra_data, 64'hA5A5A5A5A5A5A5A5);
    chk("R12 old B", rb_data, 64'hA5A5A5A5);
    @(negedge clk); wr_en = 0; #1;
    chk("R12 new A", ra_data, 64'h0123456789ABCDEF);
    chk("R12 new B", rb_data, 64'h89ABCDEF);

    // R11/R8: illegal read flags and returns zero
    wide_mode = 0; ra_idx = 15; ra_view = 3; rb_idx = 3; rb_view = 1; #1;
    chk("R8 read err", 64'(ra_err), 1);
    chk("R11 read zero", ra_data, 0);
    chk("R3 legacy high byte", rb_data, 64'h77);
    chk("R3 legacy err", 64'(rb_err), 0);
    rb_view = 4; #1;
    chk("R6 legacy wide read err", 64'(rb_err), 1);
    ra_idx = 6; ra_view = 0; #1;
    chk("R9 legacy low byte err", 64'(ra_err), 1);

    // R1: reset after activity
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    wide_mode = 1; ra_idx = 0; ra_view = 4; rb_idx = 15; rb_view = 4; #1;
    chk("R1 reset r0", ra_data, 0);
    chk("R1 reset r15", rb_data, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule